// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesizer

This block is a free-running direct digital synthesizer. A 16-bit phase register adds a programmable tuning word on every clock and wraps modulo 2^16, so with a 100 MHz reference the output frequency is `tune_word * 100 MHz / 65536`. The top bits of that phase drive four wave shapers in parallel: sine, triangle, sawtooth and square. A two-bit select picks the one that goes to a 12-bit offset-binary sample bus for an external converter, where 0x800 stands for zero.

The sine comes from a table that covers a single quarter of a period, 256 entries of 11 bits. The table is computed when the design is elaborated. The second quarter reads the table with the address bits inverted. The third and fourth quarters subtract the looked-up magnitude from mid-scale instead of adding it.

The sample bus is a valid/ready stream with a fixed latency. The generator never pauses. While `out_valid` is high and `out_ready` is low, the sample on the bus and `out_valid` do not change, and the samples the phase passes through in that time are dropped. When `out_ready` returns, the next sample accepted is the current one, not the oldest one held back. `tune_word` and `wave_sel` are plain control inputs.

Top module: `dds_multiwave`

## Requirements
- R1: On every clock out of reset the phase becomes (phase + tune_word) mod 2^16, including clocks on which the output is stalled, so the output frequency is tune_word * f_clk / 2^16.
- R2: Reset is synchronous and active high. It clears the phase to 0, drives out_valid low and sets out_data to 0x800.
- R3: Sine (wave_sel = 0). The table entry i (0..255) is round(2047 * sin(pi * (2i+1) / 1024)). The fine address is phase bits [13:6], bitwise inverted when phase bit 14 is 1. The sample is 0x800 + entry when phase bit 15 is 0 and 0x800 - entry when it is 1. Sample bit 11 therefore always equals the inverse of phase bit 15.
- R4: Triangle (wave_sel = 1). Take phase bits [14:0], invert them when phase bit 15 is 1, and output bits [14:3] of the result.
- R5: Sawtooth (wave_sel = 2). The sample is phase bits [15:4].
- R6: Square (wave_sel = 3). The sample is 0xFFF when phase bit 15 is 0 and 0x000 when it is 1.
- R7: Take a sample that is loaded on clock edge m. It is computed from the phase held just before edge m-1, with the shape that wave_sel selects at edge m. The phase after the k-th clock out of reset is k * tune_word.
- R8: out_valid is low on the first clock after reset is released, rises on the second clock and then stays high until the next reset.
- R9: While out_valid is high and out_ready is low, out_data and out_valid hold. The first edge with out_ready high loads the current sample under R7, and the skipped samples are lost.
- R10: With tune_word = 0 the phase stays at 0, so every accepted sample has the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 16 | Phase increment added on each clock |
| wave_sel | input | 2 | Shape select: 0 sine, 1 triangle, 2 sawtooth, 3 square |
| out_data | output | 12 | Offset-binary sample, 0x800 = zero |
| out_valid | output | 1 | Sample on out_data is valid |
| out_ready | input | 1 | Consumer accepts the sample on this edge |

## Verification
A unit step sweeps the sine through all 65536 phase values. This checks every table entry, both quadrant mirrors and both signs. An off-by-one in the mirrored address would put a wrong value at each quarter boundary, and a sign error would flip half the period. Triangle and sawtooth sweeps with small odd steps hit the fold at the half period, where an un-inverted fold jumps instead of turning. A large step probes the square edges. Irregular stalls check that a design which froze the phase, or replayed skipped samples, falls behind the computed phase. A select that rotates every cycle exposes a multiplexer sitting on the wrong pipeline stage. A zero step confirms that the output is constant.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_TRI    = 2'd1,
    WAVE_SAW    = 2'd2,
    WAVE_SQUARE = 2'd3
  } wave_e;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 16,
  parameter int TAP_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] tune,
  output logic [TAP_W-1:0]   phase_top
);
  typedef logic [PHASE_W-1:0] ph_t;

  ph_t  acc;
  logic armed;

  // Running phase: one addition per clock, never gated.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      armed <= 1'b0;
    end else begin
      acc   <= acc + tune;
      armed <= 1'b1;
    end
  end

  assign phase_top = acc[PHASE_W-1 -: TAP_W];

  // R1 / R10: each clock after the first out of reset adds exactly the tuning word
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    armed |-> (acc == ph_t'($past(acc) + $past(tune))))
    else $error("phase did not advance by tuning word");
endmodule

// File: rtl/dds_quarter_sine.sv
module dds_quarter_sine #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12
) (
  input  logic              half,
  input  logic              mirror,
  input  logic [ADDR_W-1:0] fine,
  output logic [DATA_W-1:0] sample
);
  localparam int  DEPTH = 1 << ADDR_W;
  localparam int  MAG_W = DATA_W - 1;
  localparam real PI_R  = 3.141592653589793;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  function automatic int quarter_point(int idx);
    real amp;
    real ang;
    amp = real'((1 << (DATA_W - 1)) - 1);
    ang = PI_R * real'(2 * idx + 1) / real'(4 * DEPTH);
    return $rtoi(amp * $sin(ang) + 0.5);
  endfunction

  logic [MAG_W-1:0]  rom [DEPTH];
  logic [ADDR_W-1:0] addr;
  logic [MAG_W-1:0]  mag;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam logic [MAG_W-1:0] POINT = MAG_W'(quarter_point(i));
    assign rom[i] = POINT;
  end

  always_comb begin
    addr = mirror ? ~fine : fine;
    mag  = rom[addr];
    if (half) sample = MID - {1'b0, mag};
    else      sample = MID + {1'b0, mag};
  end

  // R3: the folded sample lands in the half of the code range set by the phase half bit
  always_comb begin
    assert_sine_half_R3: assert (sample[DATA_W-1] == ~half)
      else $error("sine sample on wrong side of mid-scale");
  end
endmodule

// File: rtl/dds_out_stage.sv
module dds_out_stage
  import dds_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] sine_s,
  input  logic [DATA_W-1:0] tri_s,
  input  logic [DATA_W-1:0] saw_s,
  input  logic [DATA_W-1:0] sq_s,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] picked;
  logic              load;

  always_comb begin
    case (wave_e'(sel))
      WAVE_SINE:   picked = sine_s;
      WAVE_TRI:    picked = tri_s;
      WAVE_SAW:    picked = saw_s;
      WAVE_SQUARE: picked = sq_s;
      default:     picked = sine_s;
    endcase
  end

  assign load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= MID;
      out_valid <= 1'b0;
    end else if (load) begin
      out_data  <= picked;
      out_valid <= in_valid;
    end
  end

  // R9: a refused sample stays put
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("sample changed while stalled");

  // R8: once valid, the stream stays valid until reset
  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid)
    else $error("valid dropped");
endmodule

// File: rtl/dds_multiwave.sv
module dds_multiwave #(
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] tune_word,
  input  logic [1:0]         wave_sel,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_valid,
  input  logic               out_ready
);
  // Phase bits kept: half bit plus DATA_W bits below it.
  localparam int TAP_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [TAP_W-1:0]  ph;
  logic [DATA_W-1:0] sine_c, tri_c, saw_c, sq_c;
  logic [DATA_W-1:0] s1_sine, s1_tri, s1_saw, s1_sq;
  logic              s1_vld;

  dds_phase_acc #(.PHASE_W(PHASE_W), .TAP_W(TAP_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .tune      (tune_word),
    .phase_top (ph)
  );

  dds_quarter_sine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sine (
    .half   (ph[TAP_W-1]),
    .mirror (ph[TAP_W-2]),
    .fine   (ph[TAP_W-3 -: ADDR_W]),
    .sample (sine_c)
  );

  always_comb begin
    tri_c = ph[TAP_W-1] ? ~ph[TAP_W-2:0] : ph[TAP_W-2:0];
    saw_c = ph[TAP_W-1:1];
    sq_c  = ph[TAP_W-1] ? '0 : '1;
  end

  // Stage 1: all four shapes registered side by side.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_sine <= MID;
      s1_tri  <= '0;
      s1_saw  <= '0;
      s1_sq   <= '0;
      s1_vld  <= 1'b0;
    end else begin
      s1_sine <= sine_c;
      s1_tri  <= tri_c;
      s1_saw  <= saw_c;
      s1_sq   <= sq_c;
      s1_vld  <= 1'b1;
    end
  end

  // Stage 2: select and stream handshake.
  dds_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s1_vld),
    .sine_s    (s1_sine),
    .tri_s     (s1_tri),
    .saw_s     (s1_saw),
    .sq_s      (s1_sq),
    .sel       (wave_sel),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
  );
endmodule

// File: tb/sim_dds_multiwave.sv
module sim_dds_multiwave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tune_word = '0;
  logic [1:0]  wave_sel = '0;
  logic        out_ready = 1'b1;
  logic [11:0] out_data;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dds_multiwave u0 (
    .clk(clk), .rst(rst), .tune_word(tune_word), .wave_sel(wave_sel),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  function automatic int ref_sample(int ph, int sel);
    int f, q;
    ph = ph & 16'hFFFF;
    case (sel)
      0: begin
        f = (ph >> 6) & 8'hFF;
        if (((ph >> 14) & 1) == 1) f = 255 - f;
        q = $rtoi(2047.0 * $sin(3.141592653589793 * real'(2 * f + 1) / 1024.0) + 0.5);
        return (((ph >> 15) & 1) == 1) ? 2048 - q : 2048 + q;
      end
      1: begin
        f = (((ph >> 15) & 1) == 1) ? ((~ph) & 16'h7FFF) : (ph & 16'h7FFF);
        return f >> 3;
      end
      2: return ph >> 4;
      default: return (((ph >> 15) & 1) == 1) ? 0 : 4095;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // mode: 0 steady, 1 irregular stalls, 2 select rotates each cycle
  task automatic run_cfg(string tag, int tw, int sel, int ncyc, int mode);
    int exp = 0;
    @(negedge clk);
    rst = 1'b1; out_ready = 1'b1;
    tune_word = 16'(tw); wave_sel = 2'(sel);
    @(posedge clk); @(negedge clk);
    check("R2 valid in reset", int'(out_valid), 0);
    check("R2 data in reset", int'(out_data), 12'h800);
    rst = 1'b0;
    for (int k = 1; k <= ncyc; k++) begin
      int s;
      bit rdy;
      s   = (mode == 2) ? (k % 4) : sel;
      rdy = (mode == 1) ? (((k * 7) % 11) > 3) : 1'b1;
      wave_sel  = 2'(s);
      out_ready = rdy;
      @(posedge clk); @(negedge clk);
      if (k == 1) begin
        check("R8 valid low first cycle", int'(out_valid), 0);
      end else begin
        if (k == 2 || rdy) exp = ref_sample((k - 2) * tw, s);
        check("R8 valid high", int'(out_valid), 1);
        check(tag, int'(out_data), exp);
      end
    end
    out_ready = 1'b1;
  endtask

  initial begin
    run_cfg("R3 sine full sweep (R1 R7)", 1, 0, 65540, 0);
    run_cfg("R4 triangle", 3, 1, 22000, 0);
    run_cfg("R5 sawtooth", 5, 2, 13200, 0);
    run_cfg("R6 square", 16'h0123, 3, 600, 0);
    run_cfg("R9 stalled sine (R1)", 16'h3FF1, 0, 3000, 1);
    run_cfg("R9 stalled triangle", 16'h0457, 1, 1500, 1);
    run_cfg("R7 rotating select", 16'h0291, 0, 2000, 2);
    run_cfg("R10 zero step triangle", 0, 1, 40, 0);
    run_cfg("R10 zero step sine", 0, 0, 40, 0);
    run_cfg("R1 wrap large step saw", 16'hFFFB, 2, 300, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule